// File: doc/BRIEF.md
# Paged Command and Interrupt Register Front End

This block is the byte-wide host-side register file of an Ethernet controller. A host reaches sixteen byte offsets through a 4-bit address; a command register at offset 0, present on every page, picks which of three register pages the other fifteen offsets reach. The same command register also carries the run state (start/stop), a transmit request bit and a three-bit remote DMA opcode. Each write to it produces one-cycle strobes for the neighbouring transmit, receive and DMA blocks.

The block collects one-cycle event pulses from those neighbours into a sticky interrupt status register that the host clears by writing ones. A mask register gates each status bit onto a single active-high interrupt line. Page 0 reads and writes reach different registers at most offsets: reads return a byte supplied by a neighbour, and writes land in local storage that page 2 reads back. Page 1 is plain read/write storage. All pins are plain control and status levels or single-cycle pulses with no handshake. A pulse is consumed in the cycle it is high, and a neighbour that needs back-pressure must hold its own state.

Top module: `nic_regfile`

## Requirements
- R1: After reset the command register reads 0x21 (abort opcode 3'b100 in bits 5:3, stop in bit 0), the status register reads 0x80, the mask reads back 0x00, irq is low and all strobes are low.
- R2: Offset 0 reaches the command register on every page. Bits 7:6 select the page and bits 5:3 hold the DMA opcode, and both read back as written. On page 3 every other offset reads 0x00 and ignores writes.
- R3: A command write with bit 0 set sets stop (bit 0), clears start (bit 1), sets status bit 7 and pulses stop_pulse for one cycle. A write with bit 1 set and bit 0 clear sets start, clears stop and status bit 7, and pulses start_pulse. A write with both bits clear leaves the run state and both strobes unchanged.
- R4: A command write with bit 2 set sets the transmit bit and pulses xmit_pulse. A transmit-done event (event bit 1) clears the transmit bit one cycle later, unless a write setting bit 2 arrives in the same cycle.
- R5: Every command write drives dma_cmd with written bits 5:3 and pulses dma_strobe for exactly one cycle.
- R6: A pulse on evt_pulse[i] sets status bit i. The bit order is 0 received, 1 transmitted, 2 receive error, 3 transmit error, 4 overwrite, 5 counter overflow, 6 DMA complete. No status bit becomes set without its event.
- R7: A page 0 write at offset 7 clears exactly the status bits 6:0 that are written as 1. Status bit 7 is unaffected by such a write.
- R8: An event arriving in the same cycle as a clearing write leaves its status bit set.
- R9: The mask is written at offset 15 on page 0 or page 2 and reads back at page 2 offset 15 with bit 7 as 0. irq is the OR over bits 6:0 of status AND mask, so status bit 7 never raises it.
- R10: Page 0 reads at offsets other than 0 and 7 return ext_rdata, with ext_sel high. Writes at offsets 1-6 and 8-14 on page 0 or page 2 are stored and read back on page 2 at the same offset. Page 2 offset 7 reads 0x00.
- R11: Page 1 offsets 1 to 15 are independent read/write byte storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write enable for the current cycle |
| wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for reg_addr on the current page (combinational) |
| ext_rdata | input | 8 | Neighbour-supplied byte for page 0 read-side offsets |
| ext_sel | output | 1 | High when rd_data is taken from ext_rdata |
| evt_pulse | input | 7 | Event pulses, one bit per status bit 6:0 |
| irq | output | 1 | Active-high interrupt |
| start_pulse | output | 1 | One-cycle start command |
| stop_pulse | output | 1 | One-cycle stop command |
| xmit_pulse | output | 1 | One-cycle transmit request |
| dma_strobe | output | 1 | One-cycle strobe on every command write |
| dma_cmd | output | 3 | Remote DMA opcode from the last command write |

## Verification
On every cycle, the assertions check that start and stop strobes never coincide, that stop writes take effect, and that the transmit bit drops after a done event. They also check that events always land in status, that no status bit appears without an event, and that a full clear silences irq. Only the bench scenarios can show the page decoding and the read/write split on page 0. The same holds for storage independence across pages, exact write-one-clear patterns and the full mask sweep against irq.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int EVT_W  = 7;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {PG0 = 2'd0, PG1 = 2'd1, PG2 = 2'd2, PG3 = 2'd3} page_e;

  localparam logic [ADDR_W-1:0] OFF_CMD = 4'd0;
  localparam logic [ADDR_W-1:0] OFF_ISR = 4'd7;
  localparam logic [ADDR_W-1:0] OFF_IMR = 4'd15;

  localparam int CB_STOP  = 0;
  localparam int CB_START = 1;
  localparam int CB_TXP   = 2;
  localparam int CB_DMA_L = 3;
  localparam int CB_DMA_H = 5;
  localparam int CB_PG_L  = 6;
  localparam int CB_PG_H  = 7;

  localparam int EV_TXDONE = 1;

  localparam logic [DATA_W-1:0] CMD_RESET = 8'h21;
endpackage

// File: rtl/nic_cmd_reg.sv
module nic_cmd_reg
  import nic_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              tx_done,
  output logic [DATA_W-1:0] cmd_q,
  output logic              start_pulse,
  output logic              stop_pulse,
  output logic              xmit_pulse,
  output logic              dma_strobe
);
  logic       stop_q, start_q, txp_q;
  logic [2:0] dma_q;
  logic [1:0] pg_q;

  logic wr_stop, wr_start, wr_txp;
  assign wr_stop  = cmd_we && cmd_wdata[CB_STOP];
  assign wr_start = cmd_we && !cmd_wdata[CB_STOP] && cmd_wdata[CB_START];
  assign wr_txp   = cmd_we && cmd_wdata[CB_TXP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q      <= CMD_RESET[CB_STOP];
      start_q     <= CMD_RESET[CB_START];
      txp_q       <= CMD_RESET[CB_TXP];
      dma_q       <= CMD_RESET[CB_DMA_H:CB_DMA_L];
      pg_q        <= CMD_RESET[CB_PG_H:CB_PG_L];
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
      xmit_pulse  <= 1'b0;
      dma_strobe  <= 1'b0;
    end else begin
      if (wr_stop) begin
        stop_q  <= 1'b1;
        start_q <= 1'b0;
      end else if (wr_start) begin
        stop_q  <= 1'b0;
        start_q <= 1'b1;
      end
      if (wr_txp)       txp_q <= 1'b1;
      else if (tx_done) txp_q <= 1'b0;
      if (cmd_we) begin
        dma_q <= cmd_wdata[CB_DMA_H:CB_DMA_L];
        pg_q  <= cmd_wdata[CB_PG_H:CB_PG_L];
      end
      start_pulse <= wr_start;
      stop_pulse  <= wr_stop;
      xmit_pulse  <= wr_txp;
      dma_strobe  <= cmd_we;
    end
  end

  assign cmd_q = {pg_q, dma_q, txp_q, start_q, stop_q};
endmodule

// File: rtl/nic_int_ctrl.sv
module nic_int_ctrl
  import nic_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt,
  input  logic             clr_we,
  input  logic [EVT_W-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [EVT_W-1:0] mask_wdata,
  output logic [EVT_W-1:0] isr_q,
  output logic [EVT_W-1:0] imr_q,
  output logic             irq
);
  logic [EVT_W-1:0] hit;

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        isr_q[i] <= 1'b0;
        imr_q[i] <= 1'b0;
      end else begin
        if (evt[i])                     isr_q[i] <= 1'b1;
        else if (clr_we && clr_bits[i]) isr_q[i] <= 1'b0;
        if (mask_we) imr_q[i] <= mask_wdata[i];
      end
    end
    assign hit[i] = isr_q[i] & imr_q[i];
  end

  assign irq = |hit;
endmodule

// File: rtl/nic_page_store.sv
module nic_page_store
  import nic_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_a,
  input  logic              we_b,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];

  assign bank_a[0] = '0;
  assign bank_b[0] = '0;

  for (genvar k = 1; k < DEPTH; k++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_a[k] <= '0;
        bank_b[k] <= '0;
      end else begin
        if (we_a && addr == ADDR_W'(k)) bank_a[k] <= wdata;
        if (we_b && addr == ADDR_W'(k)) bank_b[k] <= wdata;
      end
    end
  end

  assign rdata_a = bank_a[addr];
  assign rdata_b = bank_b[addr];
endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              ext_sel,
  input  logic [EVT_W-1:0]  evt_pulse,
  output logic              irq,
  output logic              start_pulse,
  output logic              stop_pulse,
  output logic              xmit_pulse,
  output logic              dma_strobe,
  output logic [2:0]        dma_cmd
);
  logic [DATA_W-1:0] cr_q;
  logic [EVT_W-1:0]  isr_bits, imr_bits;
  logic [DATA_W-1:0] st0_rd, st1_rd;
  page_e             page;

  logic at_cmd, at_isr, at_imr, pg0_or_2;
  logic cmd_we, clr_we, mask_we, st0_we, st1_we;

  assign page     = page_e'(cr_q[CB_PG_H:CB_PG_L]);
  assign at_cmd   = reg_addr == OFF_CMD;
  assign at_isr   = reg_addr == OFF_ISR;
  assign at_imr   = reg_addr == OFF_IMR;
  assign pg0_or_2 = (page == PG0) || (page == PG2);

  assign cmd_we  = reg_wr && at_cmd;
  assign clr_we  = reg_wr && (page == PG0) && at_isr;
  assign mask_we = reg_wr && pg0_or_2 && at_imr;
  assign st0_we  = reg_wr && pg0_or_2 && !at_cmd && !at_isr && !at_imr;
  assign st1_we  = reg_wr && (page == PG1) && !at_cmd;

  nic_cmd_reg u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .cmd_wdata   (wdata),
    .tx_done     (evt_pulse[EV_TXDONE]),
    .cmd_q       (cr_q),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .xmit_pulse  (xmit_pulse),
    .dma_strobe  (dma_strobe)
  );

  nic_int_ctrl u_int (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt_pulse),
    .clr_we     (clr_we),
    .clr_bits   (wdata[EVT_W-1:0]),
    .mask_we    (mask_we),
    .mask_wdata (wdata[EVT_W-1:0]),
    .isr_q      (isr_bits),
    .imr_q      (imr_bits),
    .irq        (irq)
  );

  nic_page_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_a    (st0_we),
    .we_b    (st1_we),
    .addr    (reg_addr),
    .wdata   (wdata),
    .rdata_a (st0_rd),
    .rdata_b (st1_rd)
  );

  assign dma_cmd = cr_q[CB_DMA_H:CB_DMA_L];
  assign ext_sel = (page == PG0) && !at_cmd && !at_isr;

  always_comb begin
    rd_data = '0;
    if (at_cmd) begin
      rd_data = cr_q;
    end else begin
      unique case (page)
        PG0: rd_data = at_isr ? {cr_q[CB_STOP], isr_bits} : ext_rdata;
        PG1: rd_data = st1_rd;
        PG2: begin
          if (at_imr)      rd_data = {1'b0, imr_bits};
          else if (at_isr) rd_data = '0;
          else             rd_data = st0_rd;
        end
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/nic_regfile_chk.sv
module nic_regfile_chk
  import nic_reg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] wdata,
  input logic [EVT_W-1:0]  evt_pulse,
  input logic              irq,
  input logic              start_pulse,
  input logic              stop_pulse,
  input logic              xmit_pulse,
  input logic [DATA_W-1:0] cr_q,
  input logic [EVT_W-1:0]  isr_bits
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, stop_pulse})); // R3

  AST_STOP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_CMD && wdata[CB_STOP]) |=>
      (stop_pulse && cr_q[CB_STOP] && !cr_q[CB_START])); // R3

  AST_TXP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse[EV_TXDONE] && !(reg_wr && reg_addr == OFF_CMD && wdata[CB_TXP])) |=>
      !cr_q[CB_TXP]); // R4

  AST_XMIT_HAS_TXP: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_pulse |-> cr_q[CB_TXP]); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((isr_bits & ~$past(isr_bits) & ~$past(evt_pulse)) == '0)); // R6

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((isr_bits & $past(evt_pulse)) == $past(evt_pulse))); // R8

  AST_CLEAR_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && cr_q[CB_PG_H:CB_PG_L] == 2'd0 && reg_addr == OFF_ISR &&
     wdata[EVT_W-1:0] == '1 && evt_pulse == '0) |=> !irq); // R7
endmodule

bind nic_regfile nic_regfile_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .wdata       (wdata),
  .evt_pulse   (evt_pulse),
  .irq         (irq),
  .start_pulse (start_pulse),
  .stop_pulse  (stop_pulse),
  .xmit_pulse  (xmit_pulse),
  .cr_q        (cr_q),
  .isr_bits    (isr_bits)
);

// File: tb/nic_regfile_test.sv
`timescale 1ns/1ps
module nic_regfile_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic [7:0] ext_rdata;
  logic       ext_sel;
  logic [6:0] evt_pulse = '0;
  logic       irq, start_pulse, stop_pulse, xmit_pulse, dma_strobe;
  logic [2:0] dma_cmd;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign ext_rdata = {4'hA, reg_addr};

  nic_regfile uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .wdata(wdata),
    .rd_data(rd_data), .ext_rdata(ext_rdata), .ext_sel(ext_sel), .evt_pulse(evt_pulse),
    .irq(irq), .start_pulse(start_pulse), .stop_pulse(stop_pulse), .xmit_pulse(xmit_pulse),
    .dma_strobe(dma_strobe), .dma_cmd(dma_cmd)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_ev(input logic [3:0] a, input logic [7:0] d, input logic [6:0] e);
    @(negedge clk);
    reg_addr = a; wdata = d; reg_wr = 1'b1; evt_pulse = e;
    @(negedge clk);
    reg_wr = 1'b0; evt_pulse = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_ev(a, d, 7'h00);
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = rd_data;
  endtask

  logic [7:0] v;

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v); check("R1 cmd", v, 8'h21);
    rd(4'd7, v); check("R1 isr", v, 8'h80);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 strobes", {4'd0, start_pulse, stop_pulse, xmit_pulse, dma_strobe}, 8'h00);
    wr(4'd0, 8'hA0);
    rd(4'd15, v); check("R1 mask", v, 8'h00);
    wr(4'd0, 8'h20);

    // R3 start / neutral / R5 strobe
    wr(4'd0, 8'h22);
    check("R3 start strobe", {6'd0, start_pulse, stop_pulse}, 8'h02);
    check("R5 dma strobe", {4'd0, dma_strobe, dma_cmd}, 8'h0C);
    rd(4'd0, v); check("R3 cmd started", v, 8'h22);
    rd(4'd7, v); check("R3 isr bit7 cleared", v, 8'h00);
    wr(4'd0, 8'h20);
    check("R3 neutral no strobe", {6'd0, start_pulse, stop_pulse}, 8'h00);
    rd(4'd0, v); check("R3 neutral keeps", v, 8'h22);

    // R6 each event bit
    for (int b = 0; b < 7; b++) begin
      pulse(7'(1 << b));
      rd(4'd7, v); check("R6 event bit", v, 8'(1 << b));
      wr(4'd7, 8'hFF);
      rd(4'd7, v); check("R7 clear all", v, 8'h00);
    end

    // R7 exact clear patterns
    pulse(7'h7F);
    wr(4'd7, 8'h55); rd(4'd7, v); check("R7 clear 55", v, 8'h2A);
    wr(4'd7, 8'h82); rd(4'd7, v); check("R7 clear 82", v, 8'h28);
    wr(4'd0, 8'h21);
    check("R3 stop strobe", {6'd0, start_pulse, stop_pulse}, 8'h01);
    rd(4'd7, v); check("R3 stop sets bit7", v, 8'hA8);
    wr(4'd7, 8'h80); rd(4'd7, v); check("R7 bit7 unaffected", v, 8'hA8);
    wr(4'd7, 8'hFF); rd(4'd7, v); check("R7 clear keeps bit7", v, 8'h80);
    wr(4'd0, 8'h22);

    // R8 event wins over clear
    pulse(7'h02);
    wr_ev(4'd7, 8'h03, 7'h01);
    rd(4'd7, v); check("R8 event vs clear", v, 8'h01);
    wr(4'd7, 8'hFF);

    // R9 mask sweep against irq
    for (int pi = 0; pi < 4; pi++) begin
      logic [6:0] pat;
      pat = (pi == 0) ? 7'h01 : (pi == 1) ? 7'h40 : (pi == 2) ? 7'h2A : 7'h7F;
      wr(4'd7, 8'hFF);
      pulse(pat);
      for (int m = 0; m < 128; m++) begin
        wr(4'd15, 8'(m));
        check("R9 irq sweep", {7'd0, irq}, {7'd0, |(pat & 7'(m))});
      end
    end
    wr(4'd7, 8'hFF);
    wr(4'd15, 8'h5B);
    wr(4'd0, 8'hA2);
    rd(4'd15, v); check("R9 mask readback", v, 8'h5B);
    wr(4'd15, 8'hFF);
    rd(4'd15, v); check("R9 mask bit7 zero", v, 8'h7F);
    wr(4'd0, 8'h21);
    rd(4'd7, v); check("R9 stopped isr", v, 8'h80);
    check("R9 bit7 no irq", {7'd0, irq}, 8'h00);

    // R10 page 0 split
    for (int o = 1; o < 16; o++) begin
      if (o != 7) begin
        rd(4'(o), v); check("R10 ext read", v, {4'hA, 4'(o)});
        check("R10 ext_sel", {7'd0, ext_sel}, 8'h01);
      end
    end
    rd(4'd7, v); check("R10 ext_sel isr", {7'd0, ext_sel}, 8'h00);
    for (int o = 1; o < 15; o++)
      if (o != 7) wr(4'(o), 8'(o * 13 + 7));
    wr(4'd0, 8'hA0);
    for (int o = 1; o < 15; o++) begin
      rd(4'(o), v);
      check("R10 page2 readback", v, (o == 7) ? 8'h00 : 8'(o * 13 + 7));
    end
    check("R10 ext_sel page2", {7'd0, ext_sel}, 8'h00);

    // R11 page 1 storage
    wr(4'd0, 8'h60);
    for (int o = 1; o < 16; o++) wr(4'(o), ~8'(o * 29));
    for (int o = 1; o < 16; o++) begin
      rd(4'(o), v); check("R11 page1 rw", v, ~8'(o * 29));
    end
    wr(4'd0, 8'hA0);
    rd(4'd3, v); check("R11 page2 untouched", v, 8'(3 * 13 + 7));

    // R2 page 3
    wr(4'd0, 8'hE0);
    rd(4'd0, v); check("R2 cmd page3", v, 8'hE1);
    rd(4'd5, v); check("R2 page3 reads zero", v, 8'h00);
    wr(4'd5, 8'h99);
    rd(4'd5, v); check("R2 page3 write ignored", v, 8'h00);
    wr(4'd0, 8'h60);
    rd(4'd5, v); check("R2 page1 intact", v, ~8'(5 * 29));
    wr(4'd0, 8'hA0);
    rd(4'd5, v); check("R2 page2 intact", v, 8'(5 * 13 + 7));
    rd(4'd0, v); check("R2 page and opcode", v, 8'hA1);

    // R4 transmit bit
    wr(4'd0, 8'h22);
    wr(4'd0, 8'h26);
    check("R4 xmit strobe", {7'd0, xmit_pulse}, 8'h01);
    rd(4'd0, v); check("R4 txp set", v, 8'h26);
    pulse(7'h02);
    rd(4'd0, v); check("R4 txp cleared", v, 8'h22);
    rd(4'd7, v); check("R4 tx done status", v, 8'h02);
    wr_ev(4'd0, 8'h26, 7'h02);
    rd(4'd0, v); check("R4 write beats done", v, 8'h26);
    pulse(7'h02);
    rd(4'd0, v); check("R4 txp cleared again", v, 8'h22);

    // R5 opcode and single-cycle strobe
    wr(4'd0, 8'h12);
    check("R5 opcode", {4'd0, dma_strobe, dma_cmd}, 8'h0A);
    @(negedge clk);
    check("R5 strobe one cycle", {7'd0, dma_strobe}, 8'h00);
    check("R5 opcode held", {5'd0, dma_cmd}, 8'h02);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule